// File: doc/BRIEF.md
# Gated Timer/Counter with 13/16-bit Modes

This block is a single timer/counter channel. Its count is held in two byte registers, a low byte and a high byte, and it runs either as a 13-bit count or as a 16-bit count. In the 13-bit count, the five least significant bits of the low byte sit below the eight bits of the high byte. Each increment comes from one of two sources. The first is the system clock divided by 12 or by 4. The second is a falling edge on an external count pin.

Counting can be gated by an external pin. When the count steps from all ones to zero, a sticky overflow flag is raised and a one-clock pulse appears on an output. Software loads both bytes and the control register through plain write strobes and reads them back at any time. It clears the flag with a single-cycle strobe.

Top module: `gtc_timer`

## Requirements
- R1: With control bit 3 (wide) at 1, the count is the 16-bit value {high byte, low byte}. It increments by one per count event and wraps from 0xFFFF to 0x0000.
- R2: With control bit 3 at 0, the count is the 13-bit value {high byte, low byte bits 4..0}. A carry out of low-byte bit 4 enters high-byte bit 0, and the count wraps from 0x1FFF to zero.
- R3: In the 13-bit mode, low-byte bits 7..5 keep the value last written to them. They have no influence on increments, carries or the wrap point.
- R4: While control bit 0 (run) is 0, neither byte changes except through a byte write. The clock divider is held cleared.
- R5: With control bit 1 (gate) at 1, counting happens only while gate_pin is high. gate_pin is seen through a two-flop synchronizer. With gate at 0, gate_pin is ignored.
- R6: With control bit 2 (source) at 0, the count advances once every 12 clocks when control bit 4 (fast) is 0, and once every 4 clocks when it is 1. The first advance comes exactly one full period after the clock edge that loads run = 1.
- R7: A wrap sets ovf_flag on the same edge. The flag stays set until a flag_clr strobe. When a wrap and flag_clr coincide, the flag stays set.
- R8: A write strobe on either byte loads that byte on the next edge. In that cycle the increment, and any wrap it would cause, is dropped.
- R9: ovf_pulse is high for exactly the one clock cycle that follows each wrap edge, and low otherwise.
- R10: With control bit 2 at 1, the count advances once per falling edge of count_pin, after a two-flop synchronizer. Rising edges do not count.
- R11: After reset, both bytes, the control register, ovf_flag and ovf_pulse are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 5 | Control value: bit0 run, bit1 gate, bit2 source (1 = pin edges), bit3 wide, bit4 fast |
| ctrl_rdata | output | 5 | Current control register |
| lo_wr | input | 1 | Low byte write strobe |
| lo_wdata | input | 8 | Low byte write value |
| lo_rdata | output | 8 | Low byte of the count |
| hi_wr | input | 1 | High byte write strobe |
| hi_wdata | input | 8 | High byte write value |
| hi_rdata | output | 8 | High byte of the count |
| flag_clr | input | 1 | Clears the overflow flag |
| gate_pin | input | 1 | Asynchronous gate input |
| count_pin | input | 1 | Asynchronous count input |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_pulse | output | 1 | One-cycle overflow pulse |

## Verification
The bench sweeps every clock after start for both divide ratios and both widths. It starts just below the wrap point, so an off-by-one divider or a prescaler that is not cleared at start shifts every expected value. A 13-bit mode that carried through low-byte bits 7..5, or cleared them, would miss the 0x1F to 0x20 carry or corrupt the preserved upper bits. Further checks place a byte write on the exact increment edge, where a design that added after loading would show the written value plus one. They also place a flag clear on the wrap edge, where the wrong priority would leave the flag low. Gate and pin-edge runs catch a design that counts while gated or counts rising edges.

// File: rtl/gtc_pkg.sv
package gtc_pkg;

    localparam int BYTE_W      = 8;
    localparam int M0_LOW_BITS = 5;
    localparam int CTRL_W      = 5;

    typedef enum logic {
        MODE_13 = 1'b0,
        MODE_16 = 1'b1
    } gtc_mode_t;

    typedef enum logic {
        SRC_CLOCK = 1'b0,
        SRC_PIN   = 1'b1
    } gtc_src_t;

    // Packed MSB first: bit4 fast, bit3 mode, bit2 src, bit1 gate, bit0 run
    typedef struct packed {
        logic      fast;
        gtc_mode_t mode;
        gtc_src_t  src;
        logic      gate;
        logic      run;
    } gtc_ctrl_t;

    // True when the count sits at its terminal value for the given width
    function automatic logic at_terminal(input gtc_mode_t mode,
                                         input logic [BYTE_W-1:0] lo,
                                         input logic [BYTE_W-1:0] hi);
        if (mode == MODE_16)
            return (&lo) && (&hi);
        else
            return (&lo[M0_LOW_BITS-1:0]) && (&hi);
    endfunction

endpackage

// File: rtl/gtc_sync.sv
module gtc_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++)
                stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++)
                stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gtc_prescale.sv
module gtc_prescale #(
    parameter int DIV_SLOW = 12,
    parameter int DIV_FAST = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic fast,
    output logic tick
);

    localparam int MAX_DIV = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int CNT_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;
    localparam logic [CNT_W-1:0] LIM_SLOW = CNT_W'(DIV_SLOW - 1);
    localparam logic [CNT_W-1:0] LIM_FAST = CNT_W'(DIV_FAST - 1);

    logic [CNT_W-1:0] div_q;
    logic [CNT_W-1:0] limit;

    assign limit = fast ? LIM_FAST : LIM_SLOW;
    assign tick  = run && (div_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || !run || tick)
            div_q <= '0;
        else
            div_q <= div_q + CNT_W'(1);
    end

endmodule

// File: rtl/gtc_count.sv
module gtc_count
    import gtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  gtc_mode_t         mode,
    input  logic              inc,
    input  logic              lo_wr,
    input  logic [BYTE_W-1:0] lo_wdata,
    input  logic              hi_wr,
    input  logic [BYTE_W-1:0] hi_wdata,
    output logic [BYTE_W-1:0] lo_q,
    output logic [BYTE_W-1:0] hi_q,
    output logic              wrap
);

    localparam int W16 = 2 * BYTE_W;
    localparam int W13 = BYTE_W + M0_LOW_BITS;

    logic [BYTE_W-1:0] lo_n;
    logic [BYTE_W-1:0] hi_n;
    logic              bump;
    logic [W16-1:0]    sum16;
    logic [W13-1:0]    sum13;

    assign bump  = inc && !lo_wr && !hi_wr;
    assign sum16 = {hi_q, lo_q} + W16'(1);
    assign sum13 = {hi_q, lo_q[M0_LOW_BITS-1:0]} + W13'(1);

    always_comb begin
        lo_n = lo_q;
        hi_n = hi_q;
        wrap = 1'b0;
        if (bump) begin
            wrap = at_terminal(mode, lo_q, hi_q);
            if (mode == MODE_16) begin
                lo_n = sum16[BYTE_W-1:0];
                hi_n = sum16[W16-1:BYTE_W];
            end else begin
                lo_n[M0_LOW_BITS-1:0] = sum13[M0_LOW_BITS-1:0];
                hi_n = sum13[W13-1:M0_LOW_BITS];
            end
        end
        if (lo_wr) lo_n = lo_wdata;
        if (hi_wr) hi_n = hi_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

endmodule

// File: rtl/gtc_timer.sv
module gtc_timer
    import gtc_pkg::*;
#(
    parameter int DIV_SLOW    = 12,
    parameter int DIV_FAST    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rdata,
    input  logic              lo_wr,
    input  logic [BYTE_W-1:0] lo_wdata,
    output logic [BYTE_W-1:0] lo_rdata,
    input  logic              hi_wr,
    input  logic [BYTE_W-1:0] hi_wdata,
    output logic [BYTE_W-1:0] hi_rdata,
    input  logic              flag_clr,
    input  logic              gate_pin,
    input  logic              count_pin,
    output logic              ovf_flag,
    output logic              ovf_pulse
);

    gtc_ctrl_t  ctrl_q;
    logic [1:0] pins_s;
    logic       gate_s;
    logic       cnt_s;
    logic       cnt_prev;
    logic       fall;
    logic       tick;
    logic       allow;
    logic       inc;
    logic       wrap;

    // Control register
    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (ctrl_wr)
            ctrl_q <= gtc_ctrl_t'(ctrl_wdata);
    end
    assign ctrl_rdata = ctrl_q;

    // Pin synchronizers
    gtc_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({gate_pin, count_pin}),
        .q   (pins_s)
    );
    assign gate_s = pins_s[1];
    assign cnt_s  = pins_s[0];

    always_ff @(posedge clk) begin
        if (rst) cnt_prev <= 1'b0;
        else     cnt_prev <= cnt_s;
    end
    assign fall = cnt_prev && !cnt_s;

    // Clock divider
    gtc_prescale #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl_q.run),
        .fast (ctrl_q.fast),
        .tick (tick)
    );

    assign allow = ctrl_q.run && (!ctrl_q.gate || gate_s);
    assign inc   = allow && ((ctrl_q.src == SRC_PIN) ? fall : tick);

    // Count registers
    gtc_count u_cnt (
        .clk      (clk),
        .rst      (rst),
        .mode     (ctrl_q.mode),
        .inc      (inc),
        .lo_wr    (lo_wr),
        .lo_wdata (lo_wdata),
        .hi_wr    (hi_wr),
        .hi_wdata (hi_wdata),
        .lo_q     (lo_rdata),
        .hi_q     (hi_rdata),
        .wrap     (wrap)
    );

    // Overflow reporting: set has priority over clear
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag  <= 1'b0;
            ovf_pulse <= 1'b0;
        end else begin
            ovf_pulse <= wrap;
            if (wrap)
                ovf_flag <= 1'b1;
            else if (flag_clr)
                ovf_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/gtc_checker.sv
module gtc_checker
    import gtc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ctrl_run,
    input logic              lo_wr,
    input logic [BYTE_W-1:0] lo_wdata,
    input logic [BYTE_W-1:0] lo_rdata,
    input logic              hi_wr,
    input logic [BYTE_W-1:0] hi_wdata,
    input logic [BYTE_W-1:0] hi_rdata,
    input logic              flag_clr,
    input logic              ovf_flag,
    input logic              ovf_pulse
);

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_run && !lo_wr && !hi_wr) |=> ($stable(lo_rdata) && $stable(hi_rdata)));

    assert_lo_load_R8: assert property (@(posedge clk) disable iff (rst)
        lo_wr |=> (lo_rdata == $past(lo_wdata)));

    assert_hi_load_R8: assert property (@(posedge clk) disable iff (rst)
        hi_wr |=> (hi_rdata == $past(hi_wdata)));

    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |=> !ovf_pulse);

    assert_pulse_sets_flag_R7: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> ovf_flag);

    assert_flag_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> ovf_pulse);

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
        flag_clr |=> (ovf_pulse || !ovf_flag));

    assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> ((hi_rdata == '0) && (lo_rdata[M0_LOW_BITS-1:0] == '0)));

endmodule

bind gtc_timer gtc_checker i_chk (
    .clk      (clk),
    .rst      (rst),
    .ctrl_run (ctrl_rdata[0]),
    .lo_wr    (lo_wr),
    .lo_wdata (lo_wdata),
    .lo_rdata (lo_rdata),
    .hi_wr    (hi_wr),
    .hi_wdata (hi_wdata),
    .hi_rdata (hi_rdata),
    .flag_clr (flag_clr),
    .ovf_flag (ovf_flag),
    .ovf_pulse(ovf_pulse)
);

// File: tb/test_gtc_timer.sv
module test_gtc_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_wr = 1'b0;
    logic [4:0] ctrl_wdata = '0;
    logic [4:0] ctrl_rdata;
    logic       lo_wr = 1'b0;
    logic [7:0] lo_wdata = '0;
    logic [7:0] lo_rdata;
    logic       hi_wr = 1'b0;
    logic [7:0] hi_wdata = '0;
    logic [7:0] hi_rdata;
    logic       flag_clr = 1'b0;
    logic       gate_pin = 1'b0;
    logic       count_pin = 1'b0;
    logic       ovf_flag;
    logic       ovf_pulse;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    gtc_timer i_gtc_timer (
        .clk(clk), .rst(rst),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .lo_wr(lo_wr), .lo_wdata(lo_wdata), .lo_rdata(lo_rdata),
        .hi_wr(hi_wr), .hi_wdata(hi_wdata), .hi_rdata(hi_rdata),
        .flag_clr(flag_clr), .gate_pin(gate_pin), .count_pin(count_pin),
        .ovf_flag(ovf_flag), .ovf_pulse(ovf_pulse)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input string what, input int act,
                             input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic wr_ctrl(input logic [4:0] v);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic wr_bytes(input logic [7:0] lo, input logic [7:0] hi);
        @(negedge clk); lo_wr = 1'b1; lo_wdata = lo; hi_wr = 1'b1; hi_wdata = hi;
        @(negedge clk); lo_wr = 1'b0; hi_wr = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    // Cycle-by-cycle sweep; ctl bit3 wide, bit4 fast. Expected values computed arithmetically.
    task automatic sweep(input logic [4:0] ctl, input logic [7:0] lo0, input logic [7:0] hi0,
                         input int steps, input string req);
        int div;
        int modv;
        int start;
        div   = ctl[4] ? 4 : 12;
        modv  = ctl[3] ? 65536 : 8192;
        start = ctl[3] ? int'({hi0, lo0}) : int'({hi0, lo0[4:0]});
        wr_ctrl(5'b00000);
        wr_bytes(lo0, hi0);
        clear_flag();
        wr_ctrl(ctl);
        for (int j = 1; j <= steps; j++) begin
            int n;
            int total;
            int c;
            int exp_lo;
            int exp_hi;
            int exp_pulse;
            @(negedge clk);
            n = j / div;
            total = start + n;
            c = total % modv;
            if (ctl[3]) begin
                exp_lo = c % 256;
                exp_hi = c / 256;
            end else begin
                exp_lo = int'(lo0 & 8'hE0) + (c % 32);
                exp_hi = c / 32;
            end
            exp_pulse = (j % div == 0 && n > 0 && c == 0) ? 1 : 0;
            check(req, "low byte", int'(lo_rdata), exp_lo);
            check(req, "high byte", int'(hi_rdata), exp_hi);
            check("R9", "ovf_pulse", int'(ovf_pulse), exp_pulse);
            check("R7", "ovf_flag", int'(ovf_flag), (total >= modv) ? 1 : 0);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int c0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11", "low byte", int'(lo_rdata), 0);
        check("R11", "high byte", int'(hi_rdata), 0);
        check("R11", "control", int'(ctrl_rdata), 0);
        check("R11", "ovf_flag", int'(ovf_flag), 0);
        check("R11", "ovf_pulse", int'(ovf_pulse), 0);

        // R8 byte load / readback
        wr_bytes(8'h5A, 8'h3C);
        check("R8", "low byte load", int'(lo_rdata), 'h5A);
        check("R8", "high byte load", int'(hi_rdata), 'h3C);

        // R4 run = 0 holds the count
        wr_ctrl(5'b11000);
        repeat (50) @(negedge clk);
        check("R4", "low byte idle", int'(lo_rdata), 'h5A);
        check("R4", "high byte idle", int'(hi_rdata), 'h3C);

        // R6 / R1 slow divider, 16-bit
        sweep(5'b01001, 8'h00, 8'h00, 60, "R6");
        // R1 / R9 / R7 16-bit wrap with fast divider
        sweep(5'b11001, 8'hFC, 8'hFF, 40, "R1");
        // R2 / R3 13-bit wrap, upper low bits set
        sweep(5'b10001, 8'hFD, 8'hFF, 40, "R3");
        // R2 carry from low bit 4 into high byte
        sweep(5'b10001, 8'h1E, 8'h00, 20, "R2");
        // R3 upper low bits at 111 with zero count
        sweep(5'b10001, 8'hE0, 8'h00, 16, "R3");
        // R2 13-bit, slow divider
        sweep(5'b00001, 8'h9F, 8'h7F, 40, "R2");

        // R7 clear
        clear_flag();
        check("R7", "flag after clear", int'(ovf_flag), 0);

        // R8 write on the increment edge overrides it
        wr_ctrl(5'b00000);
        wr_bytes(8'h00, 8'h00);
        wr_ctrl(5'b11001);
        repeat (3) @(negedge clk);
        lo_wr = 1'b1; lo_wdata = 8'h40;
        @(negedge clk);
        lo_wr = 1'b0;
        check("R8", "write beats increment", int'(lo_rdata), 'h40);
        check("R8", "high byte untouched", int'(hi_rdata), 0);
        repeat (4) @(negedge clk);
        check("R8", "next increment", int'(lo_rdata), 'h41);

        // R7 wrap and clear on the same edge: set wins
        wr_ctrl(5'b00000);
        wr_bytes(8'hFF, 8'hFF);
        clear_flag();
        wr_ctrl(5'b11001);
        repeat (3) @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check("R7", "set beats clear", int'(ovf_flag), 1);
        check("R9", "pulse at wrap", int'(ovf_pulse), 1);
        check("R1", "wrapped count", int'({hi_rdata, lo_rdata}), 0);
        clear_flag();

        // R5 gating
        wr_ctrl(5'b00000);
        wr_bytes(8'h00, 8'h00);
        gate_pin = 1'b0;
        wr_ctrl(5'b11011);
        repeat (40) @(negedge clk);
        check("R5", "gated low holds", int'({hi_rdata, lo_rdata}), 0);
        gate_pin = 1'b1;
        repeat (40) @(negedge clk);
        check_rng("R5", "gate high counts", int'({hi_rdata, lo_rdata}), 9, 10);
        gate_pin = 1'b0;
        repeat (4) @(negedge clk);
        c0 = int'({hi_rdata, lo_rdata});
        repeat (40) @(negedge clk);
        check("R5", "gate dropped holds", int'({hi_rdata, lo_rdata}), c0);
        // gate bit 0 ignores the pin
        wr_ctrl(5'b11001);
        repeat (40) @(negedge clk);
        check_rng("R5", "gate bit off ignores pin", int'({hi_rdata, lo_rdata}) - c0, 9, 10);

        // R10 pin falling edges
        wr_ctrl(5'b00000);
        count_pin = 1'b1;
        wr_bytes(8'h00, 8'h00);
        repeat (4) @(negedge clk);
        wr_ctrl(5'b01101);
        for (int k = 0; k < 5; k++) begin
            count_pin = 1'b0;
            repeat (3) @(negedge clk);
            count_pin = 1'b1;
            repeat (3) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        check("R10", "falling edges counted", int'({hi_rdata, lo_rdata}), 5);
        count_pin = 1'b0;
        repeat (5) @(negedge clk);
        check("R10", "sixth fall", int'({hi_rdata, lo_rdata}), 6);
        count_pin = 1'b1;
        repeat (5) @(negedge clk);
        check("R10", "rise ignored", int'({hi_rdata, lo_rdata}), 6);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule